// File: doc/BRIEF.md
# Indirect Command/Data Register Target

This block is the responder half of a two-register indirection scheme on a management bus. Seen from the bus, it shows only a 16-bit command register and a 16-bit data register at its own strap address. Behind them is a two-level space of 32 devices with 32 registers each. A host first places a value in the data register, then writes a command word that names an operation, a device and a register. The block holds a self-clearing busy flag while it runs the access on its internal register-file port. A read result comes back in the data register.

When the strap address is zero, the block answers every bus address. It takes the bus address as the device number and reads or writes the addressed register directly, with no indirection. The usual arrangement of the device space is as follows: per-PHY sets from 0x00 upward, per-port sets at 0x10 plus the port number, a serial-link set at 0x0F, and two global sets at 0x1B and 0x1C. Serial framing of the bus is not part of this block. The bus appears as a simple one-cycle request with a registered read response.

Top module: `ind_target`

## Requirements
- R1: After reset the busy flag is clear, the command and data registers both read as 0x0000, and `rsp_valid` is low.
- R2: In indirect mode, register offset 0 is the command register and offset 1 is the data register. Within a command word, bit 15 reads back as busy. Bit 12 must be 1 for a valid command. Bits 11:10 carry the operation, where 2 means read and 1 means write. Bits 9:5 give the device number and bits 4:0 give the register number.
- R3: Writing the command register while idle starts a command. Busy reads back as 1 for exactly BUSY_LAT+1 cycles after the write is accepted, and reads as 0 afterwards.
- R4: A write command stores the data register's current value into the selected device/register.
- R5: A read command loads the data register with the selected register's value by the cycle in which busy clears.
- R6: A command whose operation is 0 or 3, or whose bit 12 is 0, still runs the same busy period. It leaves the register file and the data register unchanged.
- R7: While busy, bus writes to the command and data registers are ignored.
- R8: With the strap address at 0, any bus address selects that device directly. A write updates the register, and a read returns its value.
- R9: With a non-zero strap address, a request to any other bus address produces no response and has no effect. Offsets 2 to 31 read as 0x0000, and writes to them have no effect.
- R10: `rsp_valid` pulses exactly once, one cycle after each answered read, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Bus address strap; 0 selects direct mode |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Bus (PHY) address of the request |
| req_reg | input | 5 | Register offset of the request |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response data |

## Verification
The bench builds the block with BUSY_LAT=2, which keeps each busy window three cycles long. At that length the bench can poll busy every cycle, issue register writes in the middle of a window, and catch the exact cycle in which busy drops. It switches the strap between 0 and 5 while the block is idle. Direct mode is then used to seed the register file and to inspect it after indirect writes and after rejected commands, which brings the device numbers 0x0F, 0x13, 0x1B and 0x1C into play.

// File: rtl/ind_pkg.sv
package ind_pkg;
  localparam int WORD_W = 16;
  localparam int DEV_W  = 5;
  localparam int REG_W  = 5;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [REG_W-1:0] OFS_CMD  = 5'd0;
  localparam logic [REG_W-1:0] OFS_DATA = 5'd1;

  typedef struct packed {
    logic             busy;
    logic [1:0]       spare;
    logic             c22;
    logic [1:0]       op;
    logic [DEV_W-1:0] dev;
    logic [REG_W-1:0] regn;
  } cmd_word_t;
endpackage

// File: rtl/ind_regfile.sv
module ind_regfile #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ind_engine.sv
module ind_engine
  import ind_pkg::*;
#(
  parameter int BUSY_LAT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_we,
  input  logic                   data_we,
  input  logic [WORD_W-1:0]      wdata,
  input  logic [WORD_W-1:0]      rf_rdata,
  output logic [WORD_W-1:0]      cmd_rd,
  output logic [WORD_W-1:0]      data_rd,
  output logic                   rf_req,
  output logic                   rf_we,
  output logic [DEV_W+REG_W-1:0] rf_addr,
  output logic [WORD_W-1:0]      rf_wdata
);
  localparam int CW = $clog2(BUSY_LAT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_LAT);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  cmd_word_t         cmd_q;
  logic [WORD_W-1:0] data_q;
  logic              busy;
  logic              fin;
  logic              load_rd;
  logic [CW-1:0]     cnt;
  logic              op_ok;
  logic              last;

  assign op_ok = cmd_q.c22 && (cmd_q.op == OP_READ || cmd_q.op == OP_WRITE);
  assign last  = busy && !fin && (cnt == CNT_ONE);

  assign rf_req   = last && op_ok;
  assign rf_we    = rf_req && (cmd_q.op == OP_WRITE);
  assign rf_addr  = {cmd_q.dev, cmd_q.regn};
  assign rf_wdata = data_q;

  assign cmd_rd  = {busy, cmd_q[WORD_W-2:0]};
  assign data_rd = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      data_q  <= '0;
      busy    <= 1'b0;
      fin     <= 1'b0;
      load_rd <= 1'b0;
      cnt     <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (cmd_we) begin
          cmd_q <= cmd_word_t'(wdata);
          busy  <= 1'b1;
          cnt   <= CNT_LOAD;
        end
        if (data_we) data_q <= wdata;
      end else if (fin) begin
        busy <= 1'b0;
        if (load_rd) data_q <= rf_rdata;
      end else if (last) begin
        fin     <= 1'b1;
        cnt     <= '0;
        load_rd <= op_ok && (cmd_q.op == OP_READ);
      end else begin
        cnt <= cnt - CNT_ONE;
      end
    end
  end

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_q));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> $stable(data_q));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CNT_LOAD));
  // R3
  idle_rest_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt == '0 && !fin));
endmodule

// File: rtl/ind_target.sv
module ind_target
  import ind_pkg::*;
#(
  parameter int BUSY_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  strap_addr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_addr,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int AW = DEV_W + REG_W;

  logic              direct, hit, ind_hit;
  logic              cmd_we, data_we;
  logic [WORD_W-1:0] cmd_rd, data_rd;
  logic              eng_req, eng_we;
  logic [AW-1:0]     eng_addr;
  logic [WORD_W-1:0] eng_wdata;
  logic              rf_we;
  logic [AW-1:0]     rf_addr;
  logic [WORD_W-1:0] rf_wdata, rf_q;
  logic              from_rf;
  logic [WORD_W-1:0] rsp_q;

  assign direct  = (strap_addr == '0);
  assign hit     = req_valid && (direct || req_addr == strap_addr);
  assign ind_hit = hit && !direct;
  assign cmd_we  = ind_hit && req_write && (req_reg == OFS_CMD);
  assign data_we = ind_hit && req_write && (req_reg == OFS_DATA);

  ind_engine #(.BUSY_LAT(BUSY_LAT)) i_engine (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .data_we  (data_we),
    .wdata    (req_wdata),
    .rf_rdata (rf_q),
    .cmd_rd   (cmd_rd),
    .data_rd  (data_rd),
    .rf_req   (eng_req),
    .rf_we    (eng_we),
    .rf_addr  (eng_addr),
    .rf_wdata (eng_wdata)
  );

  // engine owns the port while it runs; otherwise direct-mode traffic
  assign rf_addr  = eng_req ? eng_addr : {req_addr, req_reg};
  assign rf_wdata = eng_req ? eng_wdata : req_wdata;
  assign rf_we    = eng_req ? eng_we : (hit && direct && req_write);

  ind_regfile #(.AW(AW), .DW(WORD_W)) i_regfile (
    .clk   (clk),
    .we    (rf_we),
    .addr  (rf_addr),
    .wdata (rf_wdata),
    .rdata (rf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      from_rf   <= 1'b0;
      rsp_q     <= '0;
    end else begin
      rsp_valid <= hit && !req_write;
      from_rf   <= direct;
      if (req_reg == OFS_CMD)       rsp_q <= cmd_rd;
      else if (req_reg == OFS_DATA) rsp_q <= data_rd;
      else                          rsp_q <= '0;
    end
  end

  assign rsp_data = from_rf ? rf_q : rsp_q;

  // R9
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !direct && req_addr != strap_addr) |=> !rsp_valid);
  // R10
  write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);
  // R10
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !req_write) |=> rsp_valid);
endmodule

// File: tb/test_ind_target.sv
module test_ind_target;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap = 5'd5;
  logic        rv = 1'b0, rw = 1'b0;
  logic [4:0]  ra = '0, rr = '0;
  logic [15:0] wd = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  always #10 clk = ~clk;

  ind_target #(.BUSY_LAT(LAT)) i_ind_target (
    .clk(clk), .rst(rst), .strap_addr(strap),
    .req_valid(rv), .req_write(rw), .req_addr(ra), .req_reg(rr),
    .req_wdata(wd), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] mem [int];
  logic [15:0] m_cmd = '0, m_data = '0, m_rsp_d = '0;
  bit          m_rsp_v = 0;
  int          m_left = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit dir = (strap == 5'd0);
    bit hit = rv && (dir || ra == strap);
    int k = {ra, rr};
    int ck;
    m_rsp_v = hit && !rw;
    if (m_rsp_v) begin
      if (dir)           m_rsp_d = mem.exists(k) ? mem[k] : 16'h0;
      else if (rr == 0)  m_rsp_d = {(m_left > 0), m_cmd[14:0]};
      else if (rr == 1)  m_rsp_d = m_data;
      else               m_rsp_d = 16'h0;
    end
    if (hit && dir && rw) mem[k] = wd;
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0 && m_cmd[12]) begin
        ck = m_cmd[9:0];
        if (m_cmd[11:10] == 2'd2) m_data = mem.exists(ck) ? mem[ck] : 16'h0;
        else if (m_cmd[11:10] == 2'd1) mem[ck] = m_data;
      end
    end else if (hit && !dir && rw) begin
      if (rr == 0) begin m_cmd = wd; m_left = LAT + 1; end
      else if (rr == 1) m_data = wd;
    end
  endtask

  task automatic cyc(input bit v, input bit w, input logic [4:0] a, input logic [4:0] r,
                     input logic [15:0] d, input string tag);
    rv = v; rw = w; ra = a; rr = r; wd = d;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid === m_rsp_v, {tag, " rsp_valid"}, {15'd0, rsp_valid}, {15'd0, m_rsp_v});
    if (m_rsp_v) check(rsp_data === m_rsp_d, {tag, " rsp_data"}, rsp_data, m_rsp_d);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 5'd0, 5'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d, input string tag);
    cyc(1, 1, a, r, d, tag);
  endtask

  // read and compare with a fixed expected value from the requirements
  task automatic rd_exp(input logic [4:0] a, input logic [4:0] r, input logic [15:0] exp, input string tag);
    cyc(1, 0, a, r, 16'h0, tag);
    check(rsp_valid === 1'b1 && rsp_data === exp, tag, rsp_data, exp);
  endtask

  // poll command register until busy drops; returns number of busy reads
  task automatic poll(output int ones, input string tag);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1, 0, 5'd5, 5'd0, 16'h0, tag);
      if (rsp_data[15] === 1'b1) ones++;
      else break;
    end
  endtask

  function automatic logic [15:0] mk(input logic c22, input logic [1:0] op, input logic [4:0] dev, input logic [4:0] r);
    return {1'b1, 2'b00, c22, op, dev, r};
  endfunction

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R1
    check(rsp_valid === 1'b0, "R1 rsp idle", {15'd0, rsp_valid}, 16'h0);
    rd_exp(5'd5, 5'd0, 16'h0000, "R1 cmd reset");
    rd_exp(5'd5, 5'd1, 16'h0000, "R1 data reset");

    // R8 direct mode seeds the register file
    strap = 5'd0;
    wr(5'h1B, 5'd4, 16'h1234, "R8 wr");
    // R10 no response to a write
    check(rsp_valid === 1'b0, "R10 write silent", {15'd0, rsp_valid}, 16'h0);
    wr(5'h0F, 5'd0, 16'hBEEF, "R8 wr");
    wr(5'h13, 5'd7, 16'h0A0A, "R8 wr");
    wr(5'h1C, 5'd25, 16'h0000, "R8 wr");
    rd_exp(5'h1B, 5'd4, 16'h1234, "R8 direct read");
    idle("R10 single pulse");
    check(rsp_valid === 1'b0, "R10 single pulse", {15'd0, rsp_valid}, 16'h0);
    rd_exp(5'h0F, 5'd0, 16'hBEEF, "R8 direct read");
    rd_exp(5'h13, 5'd7, 16'h0A0A, "R8 direct read");

    // R4 indirect write
    strap = 5'd5;
    wr(5'd5, 5'd1, 16'h5555, "R2 data wr");
    wr(5'd5, 5'd0, mk(1, 2'd1, 5'h1C, 5'd25), "R2 cmd wr");
    poll(ones, "R3 poll");
    check(ones == LAT + 1, "R3 busy length", 16'(ones), 16'(LAT + 1));
    rd_exp(5'd5, 5'd0, {1'b0, mk(1, 2'd1, 5'h1C, 5'd25)}[15:0] & 16'h7FFF, "R2 cmd readback");
    strap = 5'd0;
    rd_exp(5'h1C, 5'd25, 16'h5555, "R4 stored");

    // R5 indirect read
    strap = 5'd5;
    wr(5'd5, 5'd0, mk(1, 2'd2, 5'h1B, 5'd4), "R5 cmd");
    poll(ones, "R5 poll");
    check(ones == LAT + 1, "R3 busy length read", 16'(ones), 16'(LAT + 1));
    rd_exp(5'd5, 5'd1, 16'h1234, "R5 data loaded");
    wr(5'd5, 5'd0, mk(1, 2'd2, 5'h0F, 5'd0), "R5 cmd");
    for (int i = 0; i < LAT + 1; i++) idle("R5 wait");
    rd_exp(5'd5, 5'd1, 16'hBEEF, "R5 data at busy clear");

    // R6 rejected commands
    wr(5'd5, 5'd1, 16'hAAAA, "R6 data");
    wr(5'd5, 5'd0, mk(1, 2'd3, 5'h13, 5'd7), "R6 op3");
    poll(ones, "R6 poll");
    check(ones == LAT + 1, "R6 busy length", 16'(ones), 16'(LAT + 1));
    wr(5'd5, 5'd0, mk(0, 2'd1, 5'h13, 5'd7), "R6 no c22");
    poll(ones, "R6 poll");
    wr(5'd5, 5'd0, mk(1, 2'd0, 5'h13, 5'd7), "R6 op0");
    poll(ones, "R6 poll");
    rd_exp(5'd5, 5'd1, 16'hAAAA, "R6 data kept");
    strap = 5'd0;
    rd_exp(5'h13, 5'd7, 16'h0A0A, "R6 regfile kept");

    // R7 writes during busy
    strap = 5'd5;
    wr(5'd5, 5'd0, mk(1, 2'd2, 5'h13, 5'd7), "R7 cmd");
    wr(5'd5, 5'd1, 16'h7777, "R7 data while busy");
    wr(5'd5, 5'd0, mk(1, 2'd1, 5'h0F, 5'd0), "R7 cmd while busy");
    poll(ones, "R7 poll");
    rd_exp(5'd5, 5'd1, 16'h0A0A, "R7 data");
    rd_exp(5'd5, 5'd0, mk(1, 2'd2, 5'h13, 5'd7) & 16'h7FFF, "R7 cmd kept");

    // R9 foreign address and spare offsets
    wr(5'd6, 5'd1, 16'h1111, "R9 foreign wr");
    cyc(1, 0, 5'd6, 5'd1, 16'h0, "R9 foreign rd");
    check(rsp_valid === 1'b0, "R9 no answer", {15'd0, rsp_valid}, 16'h0);
    wr(5'd6, 5'd0, mk(1, 2'd1, 5'h0F, 5'd0), "R9 foreign cmd");
    rd_exp(5'd5, 5'd0, mk(1, 2'd2, 5'h13, 5'd7) & 16'h7FFF, "R9 cmd untouched");
    rd_exp(5'd5, 5'd1, 16'h0A0A, "R9 data untouched");
    wr(5'd5, 5'd2, 16'hFFFF, "R9 spare wr");
    rd_exp(5'd5, 5'd2, 16'h0000, "R9 spare reads 0");
    rd_exp(5'd5, 5'd31, 16'h0000, "R9 spare reads 0");
    strap = 5'd0;
    rd_exp(5'h0F, 5'd0, 16'hBEEF, "R9 regfile untouched");
    idle("end");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule